// File: doc/BRIEF.md
# Daisy-Chained Serial Configuration Loader

This block takes in a device's configuration bitstream one bit at a time, on the rising edges of an externally driven configuration clock. It packs the bits into wide words for the configuration fabric. After the device's own fixed bit count has been consumed, it becomes a pass-through stage. Every later bit appears on a serial output so that the next device in a chain can be loaded from the same source.

Loading waits for two conditions: an init-ready input must be high, and the three mode pins must select slave serial loading. The decision is made once, at the start. A load then runs to completion even if the pins or init-ready change. The fabric sees a stream of words, each marked by a one-cycle valid pulse. A done flag shows that the device has its full image and is now forwarding.

Top module: `serial_cfg_loader`

## Requirements
- R1: While reset is high and in the cycle after it, `done`, `cfg_dout` and `word_valid` are 0. Reset is synchronous and active high. It clears the bit count and the partial word and returns the block to waiting for a start.
- R2: The first bit is accepted on the first rising edge at which `init_ready` is 1 and the low two mode bits are `11`. No bit is accepted on any earlier edge, and no word or `done` results from such edges.
- R3: Mode codes `111` and `011` both start a load. The other six codes leave the block idle for as long as they are applied.
- R4: Once a load has started, changes on `mode_pins` or `init_ready` have no effect on the words, on `done` or on the forwarded data.
- R5: Each accepted bit is sampled on a rising edge of `cfg_clk`. Bits are packed MSB first: the first bit of a word lands in bit `WORD_W-1`.
- R6: `word_valid` is high for exactly one cycle. That cycle follows the edge that accepted the last bit of a full word, and `word_data` holds the packed word during it.
- R7: If `OWN_BITS` is not a multiple of `WORD_W`, the remaining bits are emitted as a final word. That word is left-aligned with zeros in its low bits, and its valid pulse follows the edge of the last own bit.
- R8: `done` rises right after the edge that accepts bit number `OWN_BITS`. It stays high until reset.
- R9: `cfg_dout` is 0 whenever no bit has yet been sampled in the forwarding phase. This covers the whole load and the first cycle after `done` rises.
- R10: In the forwarding phase, a bit sampled on one rising edge is driven on `cfg_dout` after the next rising edge. Forwarded bits produce no words.
- R11: A reset in the middle of a load discards that load. A later load starts again from its first bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| cfg_clk | input | 1 | Externally driven configuration clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| cfg_din | input | 1 | Serial configuration data in |
| mode_pins | input | 3 | Load mode select; `111` or `011` means slave serial |
| init_ready | input | 1 | High when loading may begin |
| cfg_dout | output | 1 | Serial data for the next device in the chain |
| word_data | output | WORD_W | Packed configuration word |
| word_valid | output | 1 | One-cycle pulse marking a new `word_data` |
| done | output | 1 | Own bit count consumed; forwarding active |

## Verification
The closest coupling is at the edge that accepts the last own bit. On that single edge the final, possibly partial, word is flushed and the block turns into a forwarder. The bench provokes this with an own count that leaves a partial trailing word. It checks that the last word and `done` appear together after that edge while `cfg_dout` still reads 0, and that the first forwarded bit only appears one edge later. A second collision comes from changing the mode pins and `init_ready` mid-load, in the same cycles in which bits are being packed. There the bench requires the word stream to stay bit-exact against its own arithmetic packing of the driven pattern.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;

    // Width of the mode select bus.
    localparam int unsigned MODE_W = 3;

    // The two low mode bits that select slave serial loading (top bit is don't care).
    localparam logic [1:0] SLAVE_SERIAL_LOW = 2'b11;

    // Load sequencing phases.
    typedef enum logic [1:0] {
        LD_WAIT    = 2'd0,
        LD_SHIFT   = 2'd1,
        LD_FORWARD = 2'd2
    } ld_state_e;

    // One accepted-bit event handed from the sequencer to the packer.
    typedef struct packed {
        logic accept;  // a bit is taken on this edge
        logic bit_val; // value of the bit
        logic last;    // it is the final own bit
    } bit_evt_t;

    // True when the mode pins ask for slave serial loading.
    function automatic logic mode_selects_serial(input logic [MODE_W-1:0] m);
        return (m[1:0] == SLAVE_SERIAL_LOW);
    endfunction

endpackage

// File: rtl/cfg_seq_ctrl.sv
module cfg_seq_ctrl
    import cfg_loader_pkg::*;
#(
    parameter int unsigned OWN_BITS = 3430400
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [MODE_W-1:0] mode_pins,
    input  logic              init_ready,
    input  logic              din,
    output bit_evt_t          evt,
    output logic              forwarding
);

    localparam int unsigned    CW       = $clog2(OWN_BITS + 1);
    localparam logic [CW-1:0]  LAST_IDX = CW'(OWN_BITS - 1);
    localparam logic [CW-1:0]  FULL_CNT = CW'(OWN_BITS);

    ld_state_e     st_q, st_d;
    logic [CW-1:0] cnt_q;
    logic          start;
    logic          accept;
    logic          last;

    // A start is only decided while waiting; afterwards the pins are ignored.
    assign start  = (st_q == LD_WAIT) && init_ready && mode_selects_serial(mode_pins);
    assign accept = start || (st_q == LD_SHIFT);
    assign last   = accept && (cnt_q == LAST_IDX);

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            LD_WAIT:    if (start) st_d = last ? LD_FORWARD : LD_SHIFT;
            LD_SHIFT:   if (last)  st_d = LD_FORWARD;
            LD_FORWARD: st_d = LD_FORWARD;
            default:    st_d = LD_WAIT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= LD_WAIT;
            cnt_q <= '0;
        end else begin
            st_q <= st_d;
            if (accept) cnt_q <= cnt_q + 1'b1;
        end
    end

    assign evt.accept  = accept;
    assign evt.bit_val = din;
    assign evt.last    = last;
    assign forwarding  = (st_q == LD_FORWARD);

    // R8
    done_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        forwarding |=> forwarding);

    // R8
    last_sets_done_chk: assert property (@(posedge clk) disable iff (rst)
        last |=> forwarding);

    // R2
    wait_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == LD_WAIT) |-> (cnt_q == '0));

    // R8
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= FULL_CNT);

    // R10
    no_accept_fwd_chk: assert property (@(posedge clk) disable iff (rst)
        forwarding |-> !accept);

endmodule

// File: rtl/cfg_word_packer.sv
module cfg_word_packer
    import cfg_loader_pkg::*;
#(
    parameter int unsigned WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  bit_evt_t          evt,
    output logic [WORD_W-1:0] word_data,
    output logic              word_valid
);

    localparam int unsigned   FW   = $clog2(WORD_W + 1);
    localparam logic [FW-1:0] FULL = FW'(WORD_W);

    logic [WORD_W-1:0] sh_q;
    logic [FW-1:0]     fill_q;
    logic [WORD_W-1:0] sh_n;
    logic [FW-1:0]     fill_n;
    logic [FW-1:0]     pad_amt;
    logic              emit;
    logic [WORD_W-1:0] aligned;
    logic [WORD_W-1:0] data_q;
    logic              valid_q;

    always_comb begin
        sh_n    = {sh_q[WORD_W-2:0], evt.bit_val};
        fill_n  = fill_q + 1'b1;
        emit    = evt.accept && ((fill_n == FULL) || evt.last);
        pad_amt = FULL - fill_n;
        aligned = sh_n << pad_amt;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q    <= '0;
            fill_q  <= '0;
            data_q  <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= emit;
            if (evt.accept) begin
                if (emit) begin
                    data_q <= aligned;
                    sh_q   <= '0;
                    fill_q <= '0;
                end else begin
                    sh_q   <= sh_n;
                    fill_q <= fill_n;
                end
            end
        end
    end

    assign word_data  = data_q;
    assign word_valid = valid_q;

    // R6
    valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        word_valid |=> !word_valid);

    // R5
    fill_range_chk: assert property (@(posedge clk) disable iff (rst)
        fill_q < FULL);

    // R7
    last_flush_chk: assert property (@(posedge clk) disable iff (rst)
        (evt.accept && evt.last) |=> (word_valid && (fill_q == '0)));

endmodule

// File: rtl/cfg_chain_fwd.sv
module cfg_chain_fwd (
    input  logic clk,
    input  logic rst,
    input  logic forwarding,
    input  logic din,
    output logic dout
);

    logic din_q;
    logic fwd_q;
    logic dout_q;

    // Stage one samples the line and notes whether it was a forwarded bit;
    // stage two launches it downstream on the next rising edge.
    always_ff @(posedge clk) begin
        if (rst) begin
            din_q  <= 1'b0;
            fwd_q  <= 1'b0;
            dout_q <= 1'b0;
        end else begin
            din_q  <= din;
            fwd_q  <= forwarding;
            dout_q <= fwd_q ? din_q : 1'b0;
        end
    end

    assign dout = dout_q;

    // R9
    dout_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !forwarding |-> !dout);

    // R10
    dout_delay_chk: assert property (@(posedge clk) disable iff (rst)
        forwarding |-> ##2 (dout == $past(din, 2)));

endmodule

// File: rtl/serial_cfg_loader.sv
module serial_cfg_loader
    import cfg_loader_pkg::*;
#(
    parameter int unsigned OWN_BITS = 3430400,
    parameter int unsigned WORD_W   = 32
) (
    input  logic              cfg_clk,
    input  logic              rst,
    input  logic              cfg_din,
    input  logic [2:0]        mode_pins,
    input  logic              init_ready,
    output logic              cfg_dout,
    output logic [WORD_W-1:0] word_data,
    output logic              word_valid,
    output logic              done
);

    bit_evt_t evt;
    logic     forwarding;

    cfg_seq_ctrl #(
        .OWN_BITS (OWN_BITS)
    ) seq_i (
        .clk        (cfg_clk),
        .rst        (rst),
        .mode_pins  (mode_pins),
        .init_ready (init_ready),
        .din        (cfg_din),
        .evt        (evt),
        .forwarding (forwarding)
    );

    cfg_word_packer #(
        .WORD_W (WORD_W)
    ) pack_i (
        .clk        (cfg_clk),
        .rst        (rst),
        .evt        (evt),
        .word_data  (word_data),
        .word_valid (word_valid)
    );

    cfg_chain_fwd fwd_i (
        .clk        (cfg_clk),
        .rst        (rst),
        .forwarding (forwarding),
        .din        (cfg_din),
        .dout       (cfg_dout)
    );

    assign done = forwarding;

    // R10
    no_word_fwd_chk: assert property (@(posedge cfg_clk) disable iff (rst)
        (done && $past(done)) |-> !word_valid);

endmodule

// File: tb/serial_cfg_loader_tb_top.sv
module serial_cfg_loader_tb_top;

    localparam int LB = 70;
    localparam int W  = 32;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         din = 1'b0;
    logic [2:0]   mode = 3'b000;
    logic         irdy = 1'b0;
    logic         dout;
    logic [W-1:0] wdata;
    logic         wvalid;
    logic         done;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    serial_cfg_loader #(.OWN_BITS(LB), .WORD_W(W)) dut_i (
        .cfg_clk    (clk),
        .rst        (rst),
        .cfg_din    (din),
        .mode_pins  (mode),
        .init_ready (irdy),
        .cfg_dout   (dout),
        .word_data  (wdata),
        .word_valid (wvalid),
        .done       (done)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
        end
    endtask

    function automatic logic pat(input int s, input int i);
        return logic'((((i * 5) + s) ^ (i >> 1) ^ (s >> (i % 5))) & 1);
    endfunction

    // Drive one bit, clock it, sample 1 ns after the edge.
    task automatic tick(input logic b);
        din = b;
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        @(posedge clk); #1;
        @(posedge clk); #1;
        chk({31'd0, done}, 0, "R1 done");
        chk({31'd0, dout}, 0, "R1 dout");
        chk({31'd0, wvalid}, 0, "R1 word_valid");
        rst = 1'b0;
    endtask

    // Full load of LB bits then forwarding; optionally disturb pins mid-load (R4).
    task automatic run_load(input logic [2:0] m, input int seed, input bit disturb);
        logic [W-1:0] acc;
        int fill;
        logic prevb;
        acc = '0; fill = 0;
        mode = m; irdy = 1'b1;
        for (int i = 0; i < LB; i++) begin
            logic b;
            logic ev;
            logic [W-1:0] ew;
            b = pat(seed, i);
            tick(b);
            if (disturb && (i == 5))  begin mode = 3'b000; irdy = 1'b0; end
            if (disturb && (i == 40)) begin mode = 3'b101; irdy = 1'b1; end
            acc = (acc << 1) | W'(b);
            fill++;
            ev = (fill == W) || (i == LB - 1);
            ew = acc << (W - fill);
            chk({31'd0, wvalid}, {31'd0, ev}, "R6 word_valid timing");
            if (ev) begin
                if (i == LB - 1) chk(wdata, ew, "R7 final partial word");
                else if (disturb) chk(wdata, ew, "R4 word under pin changes");
                else chk(wdata, ew, "R5 packed word");
                acc = '0; fill = 0;
            end
            chk({31'd0, done}, {31'd0, (i == LB - 1)}, "R8 done edge");
            chk({31'd0, dout}, 0, "R9 dout quiet");
        end
        prevb = 1'b0;
        for (int j = 0; j < 24; j++) begin
            logic b;
            b = pat(seed + 3, j);
            tick(b);
            if (j == 8) begin mode = 3'b000; irdy = 1'b0; end
            if (j == 0) chk({31'd0, dout}, 0, "R9 first forward cycle");
            else chk({31'd0, dout}, {31'd0, prevb}, "R10 forwarded bit");
            chk({31'd0, wvalid}, 0, "R10 no word when forwarding");
            chk({31'd0, done}, 1, "R8 done sticky");
            prevb = b;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #1;
        do_reset();

        // R2: good mode but init_ready low
        mode = 3'b111; irdy = 1'b0;
        for (int i = 0; i < 40; i++) begin
            tick(pat(7, i));
            chk({31'd0, wvalid}, 0, "R2 no word before init_ready");
            chk({31'd0, done}, 0, "R2 no done before init_ready");
        end
        // R3: every other mode code stays idle
        irdy = 1'b1;
        for (int m = 0; m < 8; m++) begin
            if ((m == 3) || (m == 7)) continue;
            mode = 3'(m);
            for (int i = 0; i < 36; i++) begin
                tick(pat(m, i));
                chk({31'd0, wvalid}, 0, "R3 idle mode no word");
                chk({31'd0, done}, 0, "R3 idle mode no done");
            end
        end
        run_load(3'b111, 11, 1'b0);
        do_reset();
        run_load(3'b011, 23, 1'b0);
        do_reset();
        run_load(3'b111, 37, 1'b1);
        do_reset();

        // R11: abort a load part way, then load again from the first bit
        mode = 3'b011; irdy = 1'b1;
        for (int i = 0; i < 45; i++) tick(pat(51, i));
        rst = 1'b1;
        tick(1'b1);
        chk({31'd0, done}, 0, "R11 done after abort");
        chk({31'd0, wvalid}, 0, "R11 word_valid after abort");
        chk({31'd0, dout}, 0, "R11 dout after abort");
        rst = 1'b0;
        run_load(3'b011, 64, 1'b0);

        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule